// File: doc/BRIEF.md
# Interleaved Multithread Issue Scheduler

This block picks, every clock cycle, the hardware thread that fetches the next instruction in a fine-grained multithreaded five-stage pipeline (fetch, decode, execute, memory, writeback). The default has four thread contexts. Instructions from the contexts are interleaved so that the pipeline and memory latency of any one thread is hidden behind work from the others.

Two kinds of hold-off are tracked for each thread. A memory-stall pulse marks the thread as pending, and the thread is skipped until its ready input is seen high again with no new stall. A lock-wait pulse deschedules the thread entirely until a lock-grant pulse for that thread arrives. Issue slots are then shared among the threads that remain runnable, so a single runnable thread issues every cycle. The threads that hold critical sections therefore get more slots while the others wait on a lock.

Selection is round-robin. The search starts at the thread after the one that issued last and wraps. When no thread can run, the block outputs a bubble.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset, issue_valid_o is 0, issue_tid_o is 0 and no thread is held off. The first issue goes to thread 0 when all threads are ready.
- R2: When every thread is eligible, the issued thread id is one higher than the previous one each cycle, wrapping from 3 to 0.
- R3: A thread whose ready input is low in a cycle is skipped in that cycle's selection. The search moves on to the next eligible thread in rotation order.
- R4: A memory-stall pulse for a thread excludes it from selection from that cycle on. The exclusion lasts until a cycle in which its ready input is high and its stall input is low, and the thread is eligible again in that cycle.
- R5: A lock-wait pulse for a thread deschedules it from that cycle on. The thread stays descheduled whatever its ready input does, until a lock grant for it arrives.
- R6: A lock-grant pulse for a thread makes it runnable in the same sampling cycle, so it can be issued on the next output. A grant that arrives together with a wait pulse for the same thread wins.
- R7: When no thread is eligible, issue_valid_o is 0 on the next output and issue_tid_o keeps its previous value.
- R8: The rotation point moves only on a valid issue. After a bubble, the search resumes after the last thread that actually issued.
- R9: If at least one thread is eligible, issue_valid_o is 1 on the next output. A lone eligible thread issues on consecutive cycles.
- R10: An issued thread id is always one that was eligible in the cycle it was chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready_i | input | NUM_THREADS | Per-thread ready level; bit t is thread t |
| thr_mem_stall_i | input | NUM_THREADS | Per-thread memory-stall pulse |
| thr_lock_wait_i | input | NUM_THREADS | Per-thread pulse: thread begins waiting on a lock |
| thr_lock_grant_i | input | NUM_THREADS | Per-thread pulse: lock granted, thread may run |
| issue_valid_o | output | 1 | A thread is issued this cycle |
| issue_tid_o | output | TID_W | Id of the issued thread |

## Verification
The bench aims at the edges of the hold-off bookkeeping. It covers a stall pulse while ready stays high, a stall held across low ready, a grant that coincides with a wait, and all threads descheduled while every ready input is high. A design that latched the stall too late would issue the stalled thread once. One that let a wait override a grant would lose the thread permanently. It also drives a bubble after partial rotation and checks that selection restarts after the last real issue; a design that advanced its pointer on bubbles would skip a thread. A single runnable thread must issue back-to-back, and a design that rotated blindly would insert bubbles there.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

    // Per-thread hold-off state
    typedef struct packed {
        logic lock_wait;   // descheduled until lock grant
        logic mem_pend;    // skipped until ready returns
    } thr_flags_t;

endpackage

// File: rtl/thread_flag_track.sv
module thread_flag_track
    import thread_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic mem_stall_i,
    input  logic lock_wait_i,
    input  logic lock_grant_i,
    output logic elig_o
);

    thr_flags_t flags_d, flags_q;

    always_comb begin
        flags_d           = flags_q;
        // grant wins over a simultaneous wait
        flags_d.lock_wait = (flags_q.lock_wait | lock_wait_i) & ~lock_grant_i;
        // pending stall persists until ready is seen without a new stall
        flags_d.mem_pend  = mem_stall_i | (flags_q.mem_pend & ~ready_i);
        elig_o            = ready_i & ~flags_d.lock_wait & ~flags_d.mem_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_grant_i |=> !flags_q.lock_wait);

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.lock_wait && !lock_grant_i) |=> !elig_o || lock_grant_i);

    // R4
    stall_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.mem_pend && !ready_i) |=> flags_q.mem_pend);

endmodule

// File: rtl/rr_select.sv
module rr_select #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0] elig_i,
    input  logic [TID_W-1:0]       last_i,
    output logic                   found_o,
    output logic [TID_W-1:0]       pick_o
);

    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            int idx;
            idx = int'(last_i) + k;
            if (idx >= NUM_THREADS) begin
                idx = idx - NUM_THREADS;
            end
            if (!found_o && elig_i[idx]) begin
                found_o = 1'b1;
                pick_o  = TID_W'(idx);
            end
        end
    end

    // R10
    always_comb begin
        if (found_o) begin
            pick_elig_chk: assert (elig_i[pick_o]);
        end
    end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_ready_i,
    input  logic [NUM_THREADS-1:0] thr_mem_stall_i,
    input  logic [NUM_THREADS-1:0] thr_lock_wait_i,
    input  logic [NUM_THREADS-1:0] thr_lock_grant_i,
    output logic                   issue_valid_o,
    output logic [TID_W-1:0]       issue_tid_o
);

    typedef struct packed {
        logic [TID_W-1:0] last;
        logic             vld;
        logic [TID_W-1:0] tid;
    } sched_st_t;

    sched_st_t              st_d, st_q;
    logic [NUM_THREADS-1:0] elig;
    logic                   found;
    logic [TID_W-1:0]       pick;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        thread_flag_track u_flags (
            .clk          (clk),
            .rst_n        (rst_n),
            .ready_i      (thr_ready_i[t]),
            .mem_stall_i  (thr_mem_stall_i[t]),
            .lock_wait_i  (thr_lock_wait_i[t]),
            .lock_grant_i (thr_lock_grant_i[t]),
            .elig_o       (elig[t])
        );
    end

    rr_select #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_pick (
        .elig_i  (elig),
        .last_i  (st_q.last),
        .found_o (found),
        .pick_o  (pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = found;
        if (found) begin
            st_d.tid  = pick;
            st_d.last = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= TID_W'(NUM_THREADS - 1);
            st_q.vld  <= 1'b0;
            st_q.tid  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid_o = st_q.vld;
    assign issue_tid_o   = st_q.tid;

    // R7
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig) |=> !issue_valid_o && $stable(issue_tid_o));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |=> issue_valid_o);

    // R2
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&elig) && issue_valid_o) |=> issue_tid_o == TID_W'($past(issue_tid_o) + 1'b1));

endmodule

// File: tb/sim_thread_issue_sched.sv
`timescale 1ns/1ps
module sim_thread_issue_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rdy = '0, stl = '0, wt = '0, gr = '0;
    logic       issue_valid;
    logic [1:0] issue_tid;

    int checks = 0;
    int fails  = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    logic [1:0] m_last = 2'd3;
    logic [1:0] m_tid  = 2'd0;
    logic [3:0] m_lw   = '0;
    logic [3:0] m_st   = '0;

    always #2 clk = ~clk;

    thread_issue_sched u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .thr_ready_i      (rdy),
        .thr_mem_stall_i  (stl),
        .thr_lock_wait_i  (wt),
        .thr_lock_grant_i (gr),
        .issue_valid_o    (issue_valid),
        .issue_tid_o      (issue_tid)
    );

    // driver: applies one cycle of stimulus and pushes the expected output
    task automatic step(input logic [3:0] r, input logic [3:0] s,
                        input logic [3:0] w, input logic [3:0] g, input string tag);
        logic [3:0] nlw, nst, el;
        logic       fnd;
        @(negedge clk);
        rdy = r; stl = s; wt = w; gr = g;
        nlw = (m_lw | w) & ~g;
        nst = s | (m_st & ~r);
        el  = r & ~nlw & ~nst;
        fnd = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            logic [1:0] idx;
            idx = m_last + 2'(k);
            if (!fnd && el[idx]) begin
                fnd = 1'b1;
                m_last = idx;
                m_tid  = idx;
            end
        end
        exp_q.push_back({fnd, m_tid});
        tag_q.push_back(tag);
        m_lw = nlw;
        m_st = nst;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic [2:0] e;
                string      tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({issue_valid, issue_tid} !== e) begin
                    fails++;
                    $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
                             tg, issue_valid, issue_tid, e[2], e[1:0]);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (issue_valid !== 1'b0 || issue_tid !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset: got vld=%0b tid=%0d, expected vld=0 tid=0",
                     issue_valid, issue_tid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: full rotation from thread 0
        for (int i = 0; i < 8; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R1_R2 rotation");
        // R3: not-ready threads skipped
        for (int i = 0; i < 4; i++) step(4'b1010, 4'h0, 4'h0, 4'h0, "R3 skip not ready");
        step(4'b0100, 4'h0, 4'h0, 4'h0, "R3 skip not ready");
        // R4: stall pulse with ready high, then held while ready low
        step(4'hF, 4'b0100, 4'h0, 4'h0, "R4 stall pulse");
        step(4'b1011, 4'h0, 4'h0, 4'h0, "R4 stall pending");
        step(4'b1011, 4'h0, 4'h0, 4'h0, "R4 stall pending");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R4 stall cleared");
        // R5: thread 1 waits on a lock
        step(4'hF, 4'h0, 4'b0010, 4'h0, "R5 lock wait");
        for (int i = 0; i < 5; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R5 descheduled");
        // R6: grant returns it
        step(4'hF, 4'h0, 4'h0, 4'b0010, "R6 grant");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R6 after grant");
        // R6: wait and grant together on thread 3
        step(4'hF, 4'h0, 4'b1000, 4'b1000, "R6 grant wins");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R6 grant wins");
        // R7 / R8: bubble after partial rotation, then resume
        step(4'hF, 4'h0, 4'h0, 4'h0, "R8 partial");
        for (int i = 0; i < 3; i++) step(4'h0, 4'h0, 4'h0, 4'h0, "R7 bubble");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R8 resume");
        // R9: lone thread issues back-to-back
        for (int i = 0; i < 4; i++) step(4'b0100, 4'h0, 4'h0, 4'h0, "R9 lone thread");
        // R5 / R7: all descheduled while ready high
        step(4'hF, 4'h0, 4'hF, 4'h0, "R5 all wait");
        for (int i = 0; i < 3; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R7 all descheduled");
        step(4'hF, 4'h0, 4'h0, 4'b0001, "R6 grant thread 0");
        for (int i = 0; i < 2; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R10 only granted thread");
        step(4'hF, 4'h0, 4'h0, 4'b1110, "R6 grant rest");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R2 rotation again");

        repeat (3) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule